// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a configurable set of external sources and presents one interrupt line plus a vector to a single processor. Each source is configured through two word registers on a plain 32-bit register bus. The first holds the vector, a 4-bit priority, the trigger mode (edge or level), the polarity, a mask bit and a read-only activity bit. The second holds a routing bit for processor 0. A source becomes a candidate only when it is requested, unmasked, routed and not already in service. Its priority must also be strictly above the current threshold. The threshold is the larger of the task-priority register and the highest priority still in service.

The processor takes an interrupt by reading the acknowledge register. That read returns the vector of the winning source and marks the source in service. It also clears the source's latched edge request. When no source qualifies, the read returns the programmed spurious vector instead. Writing any value to the end-of-interrupt register retires the highest-priority source that is in service. A self-clearing reset bit in the configuration register puts the whole controller back to its reset state. This takes a fixed number of cycles.

Top module: `pvic_top`

## Requirements
- R1: After reset, every source's configuration word reads 0x8000_0000: masked, inactive, with all other fields zero. The task priority reads 15, the spurious vector reads 0xFF and `irq_out` is low.
- R2: A source is a candidate only when it is requested, its mask bit (bit 31) is clear, its routing bit (bit 0 of its second word) is set, it is not in service, and its priority is above the threshold. `irq_out` follows the existence of a candidate in the same cycle.
- R3: Among candidates, the highest priority (bits 19:16) wins. Ties go to the lowest source number.
- R4: The threshold is the larger of the task priority (word 3, bits 3:0) and the highest in-service priority. A source needs a priority strictly above it, so a task priority of 15 blocks everything.
- R5: A read of word 4 returns the winner's vector (bits 7:0) and marks that source in service. If no source qualifies, the read returns the spurious vector (word 2, bits 7:0) and changes no state.
- R6: Any write to word 5 ends service of the highest-priority in-service source, with ties going to the lowest number. Word 5 reads as 0.
- R7: An edge-mode source (bit 22 = 0) latches a request on the active edge: rising when bit 23 = 1, falling when bit 23 = 0. It latches only while unmasked, and the request persists until acknowledged. An edge seen while masked is dropped.
- R8: A level-mode source (bit 22 = 1) is requested while its input is at the active level and it is unmasked. It is offered again after its service ends if the input is still active.
- R9: Bit 30 of a configuration word reads 1 while the source is requested or in service. Writes to bit 30 have no effect.
- R10: Writing 1 to bit 31 of word 0 starts an internal reset. The bit reads 1 for RST_CYC cycles and then clears itself. Afterwards all state is back at its R1 values, and bus writes made during the reset are ignored.
- R11: Word 1 reads the version in bits 7:0, the number of processors minus one in bits 12:8, and the number of sources minus one in bits 26:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (needed for acknowledge side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_in | input | NSRC | External interrupt inputs |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Errors in pending, in-service or threshold state show at the ports within a cycle. They appear as a wrong `irq_out` level or a wrong vector on the next acknowledge read. An in-service bit that is never cleared shows up differently: it raises the threshold, so lower priorities stay silent until a spurious vector comes back. A wrong latched edge either appears as an extra acknowledge or as a request lost after the input returns. The bench therefore compares `irq_out` on every cycle and the read data on every read against a model.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int PRI_W = 4;
  localparam int VEC_W = 8;

  // word offsets on the register bus
  localparam int OFS_CFG  = 0;
  localparam int OFS_FEAT = 1;
  localparam int OFS_SPUR = 2;
  localparam int OFS_CTP  = 3;
  localparam int OFS_ACK  = 4;
  localparam int OFS_EOI  = 5;
  localparam int OFS_SRC  = 8;

  // field positions in a source configuration word
  localparam int B_MASK   = 31;
  localparam int B_ACT    = 30;
  localparam int B_POL    = 23;
  localparam int B_SENSE  = 22;
  localparam int B_PRI_LO = 16;
  localparam int B_RESET  = 31;

  typedef logic [PRI_W-1:0] pri_t;
  typedef logic [VEC_W-1:0] vec_t;

  function automatic pri_t pri_max(pri_t a, pri_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [31:0] vp_word(logic mask, logic act, logic pol,
                                          logic sense, pri_t pri, vec_t vec);
    logic [31:0] w;
    w = '0;
    w[B_MASK] = mask;
    w[B_ACT] = act;
    w[B_POL] = pol;
    w[B_SENSE] = sense;
    w[B_PRI_LO +: PRI_W] = pri;
    w[VEC_W-1:0] = vec;
    return w;
  endfunction

  function automatic logic [31:0] feat_word(int unsigned nsrc, int unsigned nproc,
                                            logic [7:0] ver);
    logic [31:0] w;
    w = '0;
    w[26:16] = 11'(nsrc - 1);
    w[12:8] = 5'(nproc - 1);
    w[7:0] = ver;
    return w;
  endfunction
endpackage

// File: rtl/pvic_src.sv
module pvic_src
  import pvic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pin,
  input  logic mask,
  input  logic sense,
  input  logic pol,
  input  logic ack_hit,
  input  logic eoi_hit,
  output logic req,
  output logic isv
);
  logic act, prev_q, pend_q, isv_q, edge_seen;

  assign act = pol ? pin : ~pin;
  assign edge_seen = act & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      isv_q  <= 1'b0;
    end else if (clr) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      isv_q  <= 1'b0;
    end else begin
      prev_q <= act;
      if (edge_seen && !mask && !sense) pend_q <= 1'b1;
      else if (ack_hit)                 pend_q <= 1'b0;
      if (ack_hit)      isv_q <= 1'b1;
      else if (eoi_hit) isv_q <= 1'b0;
    end
  end

  assign req = sense ? (act & ~mask) : pend_q;
  assign isv = isv_q;

  a_r5_ack_sets_service: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ack_hit |=> isv_q);

  a_r7_masked_edge_dropped: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (mask && !pend_q) |=> !pend_q);
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
  import pvic_pkg::*;
#(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  input  pri_t             pri [N],
  output logic             valid,
  output logic [IDX_W-1:0] idx,
  output pri_t             top
);
  // strict comparison keeps the lowest index on ties
  always_comb begin
    valid = 1'b0;
    idx = '0;
    top = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!valid || pri[i] > top)) begin
        valid = 1'b1;
        idx = IDX_W'(i);
        top = pri[i];
      end
    end
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int         NSRC      = 16,
  parameter int         AW        = 8,
  parameter int         RST_CYC   = 4,
  parameter logic [7:0] VERSION   = 8'h02,
  parameter logic [7:0] SPUR_INIT = 8'hFF,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CNT_W = $clog2(RST_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_out
);
  logic [CNT_W-1:0] rcnt_q;
  logic             busy, wr_ok, rd_ok, ack_fire, eoi_fire, rst_fire;
  pri_t             ctp_q, thr_pri, isv_top, win_top;
  vec_t             spur_q;
  vec_t             vec_q [NSRC];
  pri_t             pri_q [NSRC];
  logic [NSRC-1:0]  mask_q, sense_q, pol_q, route_q, req, isv, cand;
  logic             win_valid, isv_valid;
  logic [IDX_W-1:0] win_idx, isv_idx;
  logic [31:0]      rd_mux;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign busy     = (rcnt_q != '0);
  assign wr_ok    = bus_we & ~busy;
  assign rd_ok    = bus_re & ~busy;
  assign ack_fire = rd_ok & (bus_addr == AW'(OFS_ACK));
  assign eoi_fire = wr_ok & (bus_addr == AW'(OFS_EOI));
  assign rst_fire = wr_ok & (bus_addr == AW'(OFS_CFG)) & bus_wdata[B_RESET];

  // self-clearing reset sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rcnt_q <= '0;
    else if (busy)     rcnt_q <= rcnt_q - 1'b1;
    else if (rst_fire) rcnt_q <= CNT_W'(RST_CYC);
  end

  // global registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctp_q  <= '1;
      spur_q <= SPUR_INIT;
    end else if (busy) begin
      ctp_q  <= '1;
      spur_q <= SPUR_INIT;
    end else if (wr_ok) begin
      if (bus_addr == AW'(OFS_CTP))  ctp_q  <= bus_wdata[PRI_W-1:0];
      if (bus_addr == AW'(OFS_SPUR)) spur_q <= bus_wdata[VEC_W-1:0];
    end
  end

  assign thr_pri = pri_max(ctp_q, isv_top);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic vp_wr, dst_wr, m_r, s_r, p_r, rt_r;
    vec_t v_r;
    pri_t pr_r;

    assign vp_wr  = wr_ok & (bus_addr == AW'(OFS_SRC + 2 * i));
    assign dst_wr = wr_ok & (bus_addr == AW'(OFS_SRC + 2 * i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_r <= 1'b1; s_r <= 1'b0; p_r <= 1'b0; rt_r <= 1'b0;
        v_r <= '0;   pr_r <= '0;
      end else if (busy) begin
        m_r <= 1'b1; s_r <= 1'b0; p_r <= 1'b0; rt_r <= 1'b0;
        v_r <= '0;   pr_r <= '0;
      end else begin
        if (vp_wr) begin
          m_r  <= bus_wdata[B_MASK];
          s_r  <= bus_wdata[B_SENSE];
          p_r  <= bus_wdata[B_POL];
          pr_r <= bus_wdata[B_PRI_LO +: PRI_W];
          v_r  <= bus_wdata[VEC_W-1:0];
        end
        if (dst_wr) rt_r <= bus_wdata[0];
      end
    end

    assign mask_q[i]  = m_r;
    assign sense_q[i] = s_r;
    assign pol_q[i]   = p_r;
    assign route_q[i] = rt_r;
    assign vec_q[i]   = v_r;
    assign pri_q[i]   = pr_r;

    pvic_src u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (busy),
      .pin     (src_in[i]),
      .mask    (m_r),
      .sense   (s_r),
      .pol     (p_r),
      .ack_hit (ack_fire & win_valid & (win_idx == IDX_W'(i))),
      .eoi_hit (eoi_fire & isv_valid & (isv_idx == IDX_W'(i))),
      .req     (req[i]),
      .isv     (isv[i])
    );

    assign cand[i] = req[i] & ~m_r & rt_r & ~isv[i] & (pr_r > thr_pri);
  end

  pvic_arb #(.N(NSRC)) u_win (
    .cand (cand), .pri (pri_q), .valid (win_valid), .idx (win_idx), .top (win_top)
  );

  pvic_arb #(.N(NSRC)) u_isv (
    .cand (isv), .pri (pri_q), .valid (isv_valid), .idx (isv_idx), .top (isv_top)
  );

  assign irq_out = win_valid;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(OFS_CFG):  rd_mux[B_RESET] = busy;
      AW'(OFS_FEAT): rd_mux = feat_word(NSRC, 1, VERSION);
      AW'(OFS_SPUR): rd_mux[VEC_W-1:0] = spur_q;
      AW'(OFS_CTP):  rd_mux[PRI_W-1:0] = ctp_q;
      AW'(OFS_ACK):  rd_mux[VEC_W-1:0] = win_valid ? vec_q[win_idx] : spur_q;
      default:       rd_mux = '0;
    endcase
    for (int i = 0; i < NSRC; i++) begin
      if (bus_addr == AW'(OFS_SRC + 2 * i))
        rd_mux = vp_word(mask_q[i], req[i] | isv[i], pol_q[i], sense_q[i], pri_q[i], vec_q[i]);
      if (bus_addr == AW'(OFS_SRC + 2 * i + 1))
        rd_mux = {31'b0, route_q[i]};
    end
  end

  assign bus_rdata = rd_mux;

  a_r4_full_block: assert property (@(posedge clk) disable iff (!rst_n)
    (ctp_q == '1) |-> !irq_out);

  a_r3_winner_above_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_top > ctp_q) && (win_top > isv_top));

  a_r2_winner_open: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (!mask_q[win_idx] && route_q[win_idx] && !isv[win_idx]));

  a_r6_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && isv_valid) |=> ($countones(isv) == $countones($past(isv)) - 1));

  a_r10_reset_starts: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fire |=> busy);
endmodule

// File: tb/pvic_top_tb_top.sv
module pvic_top_tb_top;
  localparam int N = 16;
  localparam int AW = 8;
  localparam int RST_CYC = 4;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we, bus_re;
  logic [31:0]   bus_wdata, bus_rdata, last_rd;
  logic [N-1:0]  src_in, src_nx;
  logic          irq_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [N-1:0] m_mask, m_sense, m_pol, m_route, m_pend, m_isv, m_prev;
  logic [7:0]   m_vec [N];
  logic [3:0]   m_pri [N];
  logic [3:0]   m_ctp;
  logic [7:0]   m_spur;
  int           m_cnt;
  logic         e_win_v, e_isv_v;
  int           e_win_i, e_isv_i;

  pvic_top #(.NSRC(N), .AW(AW), .RST_CYC(RST_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq_out(irq_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic m_reset();
    m_mask = '1; m_sense = '0; m_pol = '0; m_route = '0;
    m_pend = '0; m_isv = '0; m_prev = '0;
    for (int i = 0; i < N; i++) begin m_vec[i] = '0; m_pri[i] = '0; end
    m_ctp = 4'hF; m_spur = 8'hFF;
  endtask

  function automatic logic m_act(int i);
    return m_pol[i] ? src_in[i] : !src_in[i];
  endfunction

  function automatic logic m_req(int i);
    return m_sense[i] ? (m_act(i) && !m_mask[i]) : m_pend[i];
  endfunction

  task automatic m_eval();
    logic [3:0] ip, wp, thr;
    e_isv_v = 0; e_isv_i = 0; ip = 0;
    for (int i = 0; i < N; i++)
      if (m_isv[i] && (!e_isv_v || m_pri[i] > ip)) begin e_isv_v = 1; e_isv_i = i; ip = m_pri[i]; end
    thr = (m_ctp > ip) ? m_ctp : ip;
    e_win_v = 0; e_win_i = 0; wp = 0;
    for (int i = 0; i < N; i++)
      if (m_req(i) && !m_mask[i] && m_route[i] && !m_isv[i] && m_pri[i] > thr &&
          (!e_win_v || m_pri[i] > wp)) begin e_win_v = 1; e_win_i = i; wp = m_pri[i]; end
  endtask

  function automatic logic [31:0] m_read(int a);
    int i;
    case (a)
      0: return {m_cnt != 0, 31'b0};
      1: return {5'd0, 11'(N - 1), 3'd0, 5'd0, 8'h02};
      2: return {24'b0, m_spur};
      3: return {28'b0, m_ctp};
      4: return {24'b0, e_win_v ? m_vec[e_win_i] : m_spur};
      5: return 32'b0;
      default: begin
        if (a >= 8 && a < 8 + 2 * N) begin
          i = (a - 8) / 2;
          if (a % 2 == 0)
            return {m_mask[i], m_req(i) || m_isv[i], 6'b0, m_pol[i], m_sense[i], 2'b0,
                    m_pri[i], 8'b0, m_vec[i]};
          return {31'b0, m_route[i]};
        end
        return 32'b0;
      end
    endcase
  endfunction

  task automatic m_step(bit we, bit re, int a, logic [31:0] d);
    logic act, ed, ah, eh;
    if (m_cnt > 0) begin
      m_cnt--;
      m_reset();
      return;
    end
    for (int i = 0; i < N; i++) begin
      act = m_act(i);
      ed = act && !m_prev[i];
      ah = re && a == 4 && e_win_v && e_win_i == i;
      eh = we && a == 5 && e_isv_v && e_isv_i == i;
      if (ed && !m_mask[i] && !m_sense[i]) m_pend[i] = 1;
      else if (ah) m_pend[i] = 0;
      if (ah) m_isv[i] = 1;
      else if (eh) m_isv[i] = 0;
      m_prev[i] = act;
    end
    if (we) begin
      if (a == 0 && d[31]) m_cnt = RST_CYC;
      if (a == 2) m_spur = d[7:0];
      if (a == 3) m_ctp = d[3:0];
      if (a >= 8 && a < 8 + 2 * N) begin
        if (a % 2 == 0) begin
          m_mask[(a-8)/2] = d[31]; m_pol[(a-8)/2] = d[23]; m_sense[(a-8)/2] = d[22];
          m_pri[(a-8)/2] = d[19:16]; m_vec[(a-8)/2] = d[7:0];
        end else m_route[(a-8)/2] = d[0];
      end
    end
  endtask

  function automatic string tag_of(int a);
    case (a)
      0: return "R10 config read";
      1: return "R11 feature";
      2: return "R1 spurious reg";
      3: return "R4 task priority";
      4: return "R5 acknowledge";
      5: return "R6 eoi reads zero";
      default: return "R9 source regs";
    endcase
  endfunction

  task automatic op(bit we, bit re, int a, logic [31:0] d, string tag);
    @(negedge clk);
    src_in = src_nx;
    bus_we = we; bus_re = re; bus_addr = AW'(a); bus_wdata = d;
    #1;
    m_eval();
    check("R2 irq_out", {31'b0, irq_out}, {31'b0, e_win_v});
    if (re) begin
      last_rd = bus_rdata;
      check(tag, bus_rdata, m_read(a));
    end
    @(posedge clk);
    m_step(we, re, a, d);
  endtask

  task automatic wr(int a, logic [31:0] d);
    op(1, 0, a, d, "write");
  endtask

  task automatic rd(int a, string tag);
    op(0, 1, a, 32'b0, tag);
  endtask

  task automatic idle();
    op(0, 0, 0, 32'b0, "idle");
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    rst_n = 0; src_in = '0; src_nx = '0;
    bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
    m_reset(); m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check("R1 irq_out after reset", {31'b0, irq_out}, 32'b0);

    // reset values
    rd(8, "R1 source word");        check("R1 source masked", last_rd, 32'h8000_0000);
    rd(3, "R1 task priority");      check("R1 task priority 15", last_rd, 32'h0000_000F);
    rd(2, "R1 spurious");           check("R1 spurious FF", last_rd, 32'h0000_00FF);
    rd(1, "R11 feature");           check("R11 feature fields", last_rd, 32'h000F_0002);
    rd(4, "R5 idle ack");           check("R5 spurious when idle", last_rd, 32'h0000_00FF);
    wr(8, 32'hC000_0000);
    rd(8, "R9 write bit30");        check("R9 activity read-only", last_rd, 32'h8000_0000);

    // level sources with equal priority
    wr(14, 32'h00C6_0033); wr(15, 1);
    wr(18, 32'h00C6_0055); wr(19, 1);
    wr(3, 0);
    src_nx[3] = 1; src_nx[5] = 1;
    idle();
    rd(4, "R3 tie");                check("R3 lowest index wins tie", last_rd, 32'h33);
    rd(4, "R4 in-service");         check("R4 in-service priority blocks equal", last_rd, 32'hFF);
    wr(5, 0);
    rd(4, "R8 re-raise");           check("R8 level re-offered after eoi", last_rd, 32'h33);
    rd(5, "R6 eoi read");           check("R6 eoi reads zero", last_rd, 32'h0);
    wr(5, 0);
    src_nx[3] = 0; src_nx[5] = 0;
    idle();

    // edge source
    wr(22, 32'h0089_0077); wr(23, 1);
    src_nx[7] = 1; idle();
    src_nx[7] = 0; idle();
    #1 check("R7 edge latched", {31'b0, irq_out}, 32'b1);
    rd(22, "R9 activity");          check("R9 activity while requested", last_rd, 32'h4089_0077);
    rd(4, "R7 edge ack");           check("R7 edge vector", last_rd, 32'h77);
    rd(4, "R7 ack cleared");        check("R7 pending cleared by ack", last_rd, 32'hFF);
    wr(5, 0);
    wr(22, 32'h8089_0077);
    src_nx[7] = 1; idle();
    src_nx[7] = 0; idle();
    wr(22, 32'h0089_0077);
    idle();
    #1 check("R7 masked edge dropped", {31'b0, irq_out}, 32'b0);

    // routing and threshold (active-low level source 9)
    wr(26, 32'h0044_0099); wr(27, 0);
    idle(); #1 check("R2 unrouted blocked", {31'b0, irq_out}, 32'b0);
    wr(27, 1);
    idle(); #1 check("R2 routed delivered", {31'b0, irq_out}, 32'b1);
    wr(3, 4);
    idle(); #1 check("R4 equal to threshold blocked", {31'b0, irq_out}, 32'b0);
    wr(3, 3);
    idle(); #1 check("R4 above threshold delivered", {31'b0, irq_out}, 32'b1);
    wr(3, 15);
    idle(); #1 check("R4 fifteen blocks all", {31'b0, irq_out}, 32'b0);

    // self-clearing reset
    wr(3, 0);
    wr(0, 32'h8000_0000);
    rd(0, "R10 busy");              check("R10 reset bit reads one", last_rd, 32'h8000_0000);
    wr(3, 2);
    repeat (RST_CYC) idle();
    rd(0, "R10 done");              check("R10 reset bit cleared", last_rd, 32'h0);
    rd(26, "R10 source");           check("R10 source back to reset", last_rd, 32'h8000_0000);
    rd(3, "R10 ctp");               check("R10 write during reset ignored", last_rd, 32'hF);

    // constrained random phase
    src_nx = '0;
    for (int k = 0; k < 4000; k++) begin
      int r, a;
      if ($urandom % 3 == 0) src_nx[$urandom % N] = ~src_nx[$urandom % N];
      r = $urandom % 16;
      a = $urandom % N;
      if (r < 4)        wr(8 + 2 * a, $urandom);
      else if (r == 4)  wr(9 + 2 * a, $urandom);
      else if (r == 5)  wr(3, $urandom % 5);
      else if (r < 10)  rd(4, "R5 acknowledge");
      else if (r < 12)  wr(5, $urandom);
      else if (r < 15) begin
        a = 1 + ($urandom % (7 + 2 * N));
        rd(a, tag_of(a));
      end
      else idle();
    end

    summary();
  end
endmodule